// File: doc/BRIEF.md
# Dual 8/16-bit PWM Pulse Generator

This block makes periodic pulse waveforms from two byte-wide channels, ch0 and ch1. Each channel holds a cycle byte and a duty byte in buffer registers loaded through a small write port. A running down-counter copies those buffers only when it starts or when it wraps, so a value written mid-period never cuts short the period in progress.

The `mode` input picks one of three arrangements. In split mode the two channels are independent 8-bit generators. In prescaler mode, ch0 wraps to give one count pulse to ch1, and ch1 counts only on those pulses. In wide mode the two cycle bytes join into one 16-bit period and the two duty bytes join into one 16-bit duty, with ch1 supplying the upper byte. Software changes the mode only while both run bits are low.

Top module: `pwm_dual_gen`

## Requirements
- R1: After reset both outputs are low. Both cycle buffers hold 0xFF and both duty buffers hold 0x00. Write addresses are: 0 for the ch0 cycle, 1 for the ch1 cycle, 2 for the ch0 duty and 3 for the ch1 duty.
- R2: In split mode (`mode` 0, with 3 treated the same), a channel with cycle C and duty D repeats every C clocks. Its counter goes from C-1 down to 0. The output is high while the counter is below D, so it is high for the last min(D,C) clocks of each period.
- R3: On the first rising clock edge that samples a channel's run bit high, the channel loads from its buffers, and that edge is the first clock of a period.
- R4: In the 8-bit modes, a cycle value of 0x00 or 0x01 behaves as 2.
- R5: A cycle or duty buffer written during a period takes effect at the next wrap. The period in progress completes with the old values.
- R6: In prescaler mode (`mode` 1), ch1 moves one count for each ch0 wrap. With ch0 cycle C0, ch1 cycle C1 and ch1 duty D1, `pwm_out[1]` repeats every C0*C1 clocks and is high for the last min(D1,C1)*C0 of them.
- R7: In wide mode (`mode` 2), the period is {ch1 cycle, ch0 cycle} and the duty is {ch1 duty, ch0 duty}. The result drives `pwm_out[0]` under `run[0]`, and `pwm_out[1]` stays low.
- R8: In wide mode, if only the upper cycle byte is written, the next wrap combines it with the lower byte held from before.
- R9: In wide mode, a period value of 0x0000 or 0x0001 behaves as 2.
- R10: While a run bit is low, its output is low from the next clock edge on and its counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the buffer registers |
| wr_addr | input | 2 | Buffer register select |
| wr_data | input | 8 | Byte to write |
| mode | input | 2 | 0/3 split, 1 prescaler, 2 wide |
| run | input | 2 | Per-channel run enable (run[0] also runs wide mode) |
| pwm_out | output | 2 | Pulse outputs for ch0 and ch1 |

## Verification
The hardest case to reach is a buffer write that lands inside a running period. It must stay invisible until the wrap edge and then take effect exactly on it. The bench counts edges from the run edge and writes at a chosen edge, both in split mode and in wide mode with an upper-byte-only write. It then samples every cycle across the boundary against a piecewise arithmetic model. Prescaler timing is reached by starting both channels on the same edge and comparing every cycle of two full C0*C1 periods.

// File: rtl/pwm_pkg.sv
// Shared definitions for the dual PWM generator.
// Assumes byte-wide buffer registers on a two-bit address.
package pwm_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT     = 2'd0,
        MODE_PRESC     = 2'd1,
        MODE_WIDE      = 2'd2,
        MODE_SPLIT_ALT = 2'd3
    } pwm_mode_e;

    localparam logic [1:0] ADDR_CYC0  = 2'd0;
    localparam logic [1:0] ADDR_CYC1  = 2'd1;
    localparam logic [1:0] ADDR_DUTY0 = 2'd2;
    localparam logic [1:0] ADDR_DUTY1 = 2'd3;
endpackage

// File: rtl/pwm_cfg_regs.sv
// Buffer registers for cycle and duty of both channels.
// Assumes writes are single-cycle strobes; reset values follow R1.
module pwm_cfg_regs
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cyc0,
    output logic [W-1:0] cyc1,
    output logic [W-1:0] duty0,
    output logic [W-1:0] duty1
);
    // Capture the addressed byte; cycles reset to all ones, duties to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc0  <= '1;
            cyc1  <= '1;
            duty0 <= '0;
            duty1 <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CYC0:  cyc0  <= wr_data;
                ADDR_CYC1:  cyc1  <= wr_data;
                ADDR_DUTY0: duty0 <= wr_data;
                default:    duty1 <= wr_data;
            endcase
        end
    end
endmodule

// File: rtl/pwm_counter.sv
// One down-counting pulse generator of width W.
// Loads cycle and duty from its buffers on start and on every wrap.
// Counts only when tick is high. Cycle values below 2 run as 2.
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] cycle,
    input  logic [W-1:0] duty,
    output logic         expire,
    output logic         out
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] duty_q;
    logic         active_q;
    logic [W-1:0] eff_cycle;

    // Clamp illegal short cycles to the shortest legal one.
    always_comb eff_cycle = (cycle < W'(2)) ? W'(2) : cycle;

    // Start, count down and reload at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            duty_q   <= '0;
            active_q <= 1'b0;
        end else if (!run) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (!active_q) begin
            active_q <= 1'b1;
            cnt_q    <= eff_cycle - W'(1);
            duty_q   <= duty;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q  <= eff_cycle - W'(1);
                duty_q <= duty;
            end else begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

    // Wrap marker and waveform.
    always_comb begin
        expire = active_q && tick && (cnt_q == '0);
        out    = active_q && (cnt_q < duty_q);
    end
endmodule

// File: rtl/pwm_dual_gen.sv
// Dual 8/16-bit PWM generator top.
// Routes buffers, run bits and ticks to two byte counters and one wide counter.
// Assumes the mode changes only while both run bits are low.
module pwm_dual_gen
    import pwm_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [CH_W-1:0] wr_data,
    input  logic [1:0]      mode,
    input  logic [1:0]      run,
    output logic [1:0]      pwm_out
);
    localparam int WIDE_W = 2 * CH_W;

    pwm_mode_e       mode_e;
    logic [CH_W-1:0] cyc0, cyc1, duty0, duty1;
    logic            expire0, expire1, expire_w;
    logic            out0, out1, out_w;
    logic            run0, run1, run_w, tick1;
    logic            is_wide;

    // Decode the mode and steer the run enables and ch1 tick.
    always_comb begin
        mode_e  = pwm_mode_e'(mode);
        is_wide = (mode_e == MODE_WIDE);
        run0    = run[0] && !is_wide;
        run1    = run[1] && !is_wide;
        run_w   = run[0] && is_wide;
        tick1   = (mode_e == MODE_PRESC) ? expire0 : 1'b1;
    end

    pwm_cfg_regs #(.W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cyc0(cyc0), .cyc1(cyc1), .duty0(duty0), .duty1(duty1)
    );

    pwm_counter #(.W(CH_W)) u_ch0 (
        .clk(clk), .rst_n(rst_n), .run(run0), .tick(1'b1),
        .cycle(cyc0), .duty(duty0), .expire(expire0), .out(out0)
    );

    pwm_counter #(.W(CH_W)) u_ch1 (
        .clk(clk), .rst_n(rst_n), .run(run1), .tick(tick1),
        .cycle(cyc1), .duty(duty1), .expire(expire1), .out(out1)
    );

    pwm_counter #(.W(WIDE_W)) u_wide (
        .clk(clk), .rst_n(rst_n), .run(run_w), .tick(1'b1),
        .cycle({cyc1, cyc0}), .duty({duty1, duty0}), .expire(expire_w), .out(out_w)
    );

    // Select the waveform for each output pin.
    always_comb begin
        pwm_out[0] = is_wide ? out_w : out0;
        pwm_out[1] = is_wide ? 1'b0 : out1;
    end
endmodule

// File: rtl/pwm_dual_gen_chk.sv
// Property checker for pwm_dual_gen, attached through bind.
// Watches the ports plus the ch0 wrap and the ch1 counter state.
module pwm_dual_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic [1:0]   run,
    input logic [1:0]   pwm_out,
    input logic         exp0,
    input logic         act1,
    input logic [W-1:0] cnt1
);
    // R10: a low run bit silences its output from the next edge on.
    a_r10_stop_low0: assert property (@(posedge clk) disable iff (!rst_n)
        !run[0] |=> !pwm_out[0]);
    a_r10_stop_low1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2 && !run[1]) |=> !pwm_out[1]);
    // R7: wide mode keeps the second pin quiet.
    a_r7_wide_pin1_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> !pwm_out[1]);
    // R4: periods of at least two clocks never wrap on consecutive edges.
    a_r4_no_double_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        exp0 |=> !exp0);
    // R6: without a ch0 wrap the prescaled ch1 counter holds.
    a_r6_presc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && run[1] && act1 && !exp0) |=> (cnt1 == $past(cnt1)));
endmodule

bind pwm_dual_gen pwm_dual_gen_chk #(.W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .pwm_out(pwm_out),
    .exp0(expire0), .act1(u_ch1.active_q), .cnt1(u_ch1.cnt_q)
);

// File: tb/pwm_dual_gen_test.sv
`timescale 1ns/1ps
module pwm_dual_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] mode = 2'd0;
    logic [1:0] run = 2'd0;
    logic [1:0] pwm_out;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    pwm_dual_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .run(run), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int n, input bit got, input bit exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s n=%0d actual=%0b expected=%0b", req, n, got, exp);
        end
    endtask

    // Split-mode level after n edges since the run edge (R2, R4).
    function automatic bit lvl(input int c, input int d, input int n);
        int e = (c < 2) ? 2 : c;
        int p = (n - 1) % e;
        return (e - 1 - p) < d;
    endfunction

    // Prescaled ch1 level (R6).
    function automatic bit plvl(input int c0, input int c1, input int d1, input int n);
        int e0 = (c0 < 2) ? 2 : c0;
        int e1 = (c1 < 2) ? 2 : c1;
        int p = (n - 1) % (e0 * e1);
        return (e1 - 1 - p / e0) < d1;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_all(input string req);
        run = 2'b00;
        @(negedge clk);
        chk(req, 0, pwm_out[0], 1'b0);
        chk(req, 0, pwm_out[1], 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cs[5] = '{2, 3, 5, 17, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 0, pwm_out[0], 1'b0);
        chk("R1", 0, pwm_out[1], 1'b0);

        // R1: reset cycles of 0xFF, ch1 duty left at reset 0.
        wr(2'd2, 8'h80);
        run = 2'b11;
        for (int n = 1; n <= 510; n++) begin
            @(negedge clk);
            chk("R1", n, pwm_out[0], lvl(255, 128, n));
            chk("R1", n, pwm_out[1], 1'b0);
        end
        stop_all("R10");

        // R2/R3: split-mode sweep over cycles and duties.
        foreach (cs[i]) begin
            for (int k = 0; k < 5; k++) begin
                int c0 = cs[i];
                int d0 = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? c0 / 2 : (k == 3) ? c0 : 255;
                int c1 = (c0 % 7) + 2 + k;
                int d1 = c1 - 1 - (k % 2);
                wr(2'd0, 8'(c0)); wr(2'd2, 8'(d0));
                wr(2'd1, 8'(c1)); wr(2'd3, 8'(d1));
                run = 2'b11;
                for (int n = 1; n <= 2 * c0 + 2; n++) begin
                    @(negedge clk);
                    chk("R2", n, pwm_out[0], lvl(c0, d0, n));
                    chk("R3", n, pwm_out[1], lvl(c1, d1, n));
                end
                stop_all("R10");
            end
        end

        // R10: idle outputs stay low over several clocks.
        for (int n = 1; n <= 5; n++) begin
            @(negedge clk);
            chk("R10", n, pwm_out[0], 1'b0);
            chk("R10", n, pwm_out[1], 1'b0);
        end

        // R4: illegal cycle values run as 2.
        wr(2'd0, 8'h00); wr(2'd2, 8'h01);
        wr(2'd1, 8'h01); wr(2'd3, 8'h01);
        run = 2'b11;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            chk("R4", n, pwm_out[0], lvl(2, 1, n));
            chk("R4", n, pwm_out[1], lvl(2, 1, n));
        end
        stop_all("R10");

        // R5: mid-period write of cycle and duty on ch0.
        wr(2'd0, 8'd10); wr(2'd2, 8'd5);
        run = 2'b01;
        for (int n = 1; n <= 22; n++) begin
            @(negedge clk);
            chk("R5", n, pwm_out[0], (n <= 10) ? lvl(10, 5, n) : lvl(4, 2, n - 10));
            if (n == 3) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd4; end
            else if (n == 4) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd2; end
            else wr_en = 1'b0;
        end
        stop_all("R10");

        // R6: prescaler mode, two full periods.
        mode = 2'd1;
        wr(2'd0, 8'd3); wr(2'd1, 8'd4); wr(2'd3, 8'd2); wr(2'd2, 8'd1);
        run = 2'b11;
        for (int n = 1; n <= 26; n++) begin
            @(negedge clk);
            chk("R6", n, pwm_out[1], plvl(3, 4, 2, n));
            chk("R6", n, pwm_out[0], lvl(3, 1, n));
        end
        stop_all("R10");

        // R7/R8: wide mode 0x0105, upper byte rewritten mid-period.
        mode = 2'd2;
        wr(2'd1, 8'h01); wr(2'd0, 8'h05); wr(2'd3, 8'h00); wr(2'd2, 8'h80);
        run = 2'b11;
        for (int n = 1; n <= 261 + 517 + 4; n++) begin
            @(negedge clk);
            if (n <= 261) chk("R7", n, pwm_out[0], lvl(261, 128, n));
            else          chk("R8", n, pwm_out[0], lvl(517, 128, n - 261));
            chk("R7", n, pwm_out[1], 1'b0);
            if (n == 100) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h02; end
            else wr_en = 1'b0;
        end
        stop_all("R10");

        // R9: wide period of 0x0001 runs as 2.
        wr(2'd1, 8'h00); wr(2'd0, 8'h01); wr(2'd2, 8'h01);
        run = 2'b01;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            chk("R9", n, pwm_out[0], lvl(2, 1, n));
        end
        stop_all("R10");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule